// File: doc/BRIEF.md
# Timed-Arm Byte Memory Controller

This block sits between a CPU register bus and a small byte-wide nonvolatile data array. Software sees four byte registers: a low address byte, a high address part, a data byte and a control byte. The control byte has three live bits: an arm bit that enables writes, a write strobe and a read strobe. A read strobe completes in a couple of cycles and leaves the addressed byte in the data register. A write strobe starts a long programming cycle whose length is set by a cycle-count parameter. The write strobe bit then acts as a busy flag until hardware clears it.

Writes are protected by a two-step unlock. Software first sets the arm bit with the strobe bit written as zero. It must then issue the write strobe before the arm bit expires, which happens a fixed number of cycles later. Each accepted strobe also holds the CPU stall output for a fixed number of cycles. Register changes during programming, and read strobes issued during programming, are reported on one-cycle error outputs.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, `cpu_stall`, `err_corrupt` and `err_rd_busy` are low, and every array location holds 0xFF.
- R2: A control write with bit 2 = 1 and bit 1 = 0 sets the arm bit, which reads back as control bit 2. Hardware clears it ARM_CYCLES (default 4) clock edges after the arming edge. A control write with bits 2 and 1 both set does not arm.
- R3: A control write with bit 1 = 1, presented on any of the ARM_CYCLES edges following the arming edge, starts programming. Control bit 1 then reads 1 for exactly PROG_CYCLES cycles (default 2500, or 4000 when SLOW_SEL = 1), then returns to 0 with the data byte stored at the current address.
- R4: A write strobe issued while the arm bit is clear has no effect: busy stays 0, no stall occurs, and the array is unchanged. This includes a strobe on the edge after the arm window has expired.
- R5: An accepted write strobe drives `cpu_stall` high for exactly 2 cycles, starting right after the strobe edge.
- R6: A control write with bit 0 = 1 and bit 1 = 0, while not busy, sets control bit 0 for one cycle. The addressed byte is then in the data register, bit 0 has cleared, and `cpu_stall` is high for exactly 4 cycles after the strobe edge.
- R7: Writing the low address, high address or data register while programming raises `err_corrupt` for the one cycle after that edge. The stored value of that write is not guaranteed.
- R8: A read strobe issued while programming is ignored: control bit 0 stays 0, the data register keeps its value, and `err_rd_busy` is high for the one cycle after that edge.
- R9: The register select codes are 0 = low address byte, 1 = high address part, 2 = data, 3 = control. The address is {high part, low byte}, ADDR_W bits wide (default 9), and locations differing only in the high part are distinct.
- R10: Reads return the control byte as {5'b0, arm, busy, read} and the high address part zero-extended to 8 bits. Only its ADDR_W-8 low bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one per cycle |
| reg_sel | input | 2 | Register select (0 addr low, 1 addr high, 2 data, 3 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| cpu_stall | output | 1 | CPU stall request after an accepted strobe |
| err_corrupt | output | 1 | One-cycle pulse: address or data changed during programming |
| err_rd_busy | output | 1 | One-cycle pulse: read strobe refused during programming |

## Verification
The bench samples on the falling edge, half a cycle after each strobe edge E, and checks each result at a fixed offset from E:
- The arm bit, the busy bit and the error pulses are visible after E.
- The arm bit has gone after E+4.
- The read byte is in the data register after E+1.
- The write stall has ended after E+2, and the read stall after E+4.
- Busy is counted on every falling edge until it drops, and the count must equal PROG_CYCLES.

The arm-window boundary is tested with strobes landing on E+4 (accepted) and E+5 (ignored).

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA    = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    localparam int CB_READ  = 0;
    localparam int CB_WRITE = 1;
    localparam int CB_ARM   = 2;

    localparam int STALL_WR_CYC = 2;
    localparam int STALL_RD_CYC = 4;
    localparam int STALL_W      = 3;
endpackage

// File: rtl/nvm_countdown.sv
module nvm_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         active,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == W'(1));

    // idle counter stays idle without a load (supports R3 timing)
    p_idle_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !active) |=> !active);
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int ARM_CYCLES = 4,
    parameter int PROG_FAST  = 2500,
    parameter int PROG_SLOW  = 4000,
    parameter bit SLOW_SEL   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       cpu_stall,
    output logic       err_corrupt,
    output logic       err_rd_busy
);
    localparam int HI_W        = ADDR_W - 8;
    localparam int PROG_CYCLES = SLOW_SEL ? PROG_SLOW : PROG_FAST;
    localparam int PROG_W      = $clog2(PROG_CYCLES + 1);
    localparam int ARM_W       = $clog2(ARM_CYCLES + 1);

    typedef struct packed {
        logic [7:0]      addr_lo;
        logic [HI_W-1:0] addr_hi;
        logic [7:0]      data;
        logic            rd_pend;
        logic            err_c;
        logic            err_r;
    } state_t;

    state_t s_d, s_q;

    logic              armed, busy, prog_last, stall_on;
    logic [7:0]        mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic              ctrl_wr, arm_go, wr_go, rd_go, rd_blk;
    logic [STALL_W-1:0] stall_val;

    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
    assign arm_go  = ctrl_wr && !busy && reg_wdata[CB_ARM] && !reg_wdata[CB_WRITE];
    assign wr_go   = ctrl_wr && !busy && reg_wdata[CB_WRITE] && armed;
    assign rd_go   = ctrl_wr && !busy && reg_wdata[CB_READ] && !reg_wdata[CB_WRITE];
    assign rd_blk  = ctrl_wr && busy && reg_wdata[CB_READ];
    assign stall_val = wr_go ? STALL_W'(STALL_WR_CYC) : STALL_W'(STALL_RD_CYC);
    assign mem_addr  = {s_q.addr_hi, s_q.addr_lo};

    nvm_countdown #(.W(ARM_W)) u_arm (
        .clk(clk), .rst_n(rst_n), .load(arm_go),
        .load_val(ARM_W'(ARM_CYCLES)), .active(armed), .last()
    );

    nvm_countdown #(.W(PROG_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .load(wr_go),
        .load_val(PROG_W'(PROG_CYCLES)), .active(busy), .last(prog_last)
    );

    nvm_countdown #(.W(STALL_W)) u_stall (
        .clk(clk), .rst_n(rst_n), .load(wr_go || rd_go),
        .load_val(stall_val), .active(stall_on), .last()
    );

    nvm_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(prog_last),
        .addr(mem_addr), .wdata(s_q.data), .rdata(mem_rdata)
    );

    always_comb begin
        s_d       = s_q;
        s_d.err_c = reg_wr && busy && (reg_sel != SEL_CTRL);
        s_d.err_r = rd_blk;
        if (s_q.rd_pend) begin
            s_d.data    = mem_rdata;
            s_d.rd_pend = 1'b0;
        end
        if (reg_wr) begin
            unique case (reg_sel)
                SEL_ADDR_LO: s_d.addr_lo = reg_wdata;
                SEL_ADDR_HI: s_d.addr_hi = reg_wdata[HI_W-1:0];
                SEL_DATA:    s_d.data    = reg_wdata;
                default:     ;
            endcase
        end
        if (rd_go) s_d.rd_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (reg_sel)
            SEL_ADDR_LO: reg_rdata = s_q.addr_lo;
            SEL_ADDR_HI: reg_rdata = 8'(s_q.addr_hi);
            SEL_DATA:    reg_rdata = s_q.data;
            default:     reg_rdata = {5'b0, armed, busy, s_q.rd_pend};
        endcase
    end

    assign cpu_stall   = stall_on;
    assign err_corrupt = s_q.err_c;
    assign err_rd_busy = s_q.err_r;

    // checker-side age of the arm bit
    logic [ARM_W:0] arm_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      arm_age_q <= '0;
        else if (arm_go) arm_age_q <= (ARM_W+1)'(1);
        else if (armed)  arm_age_q <= arm_age_q + 1'b1;
        else             arm_age_q <= '0;
    end

    p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_go |=> armed);
    p_arm_expires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (arm_age_q <= (ARM_W+1)'(ARM_CYCLES)));
    p_busy_ends_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(prog_last));
    p_unarmed_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[CB_WRITE] && !armed && !busy) |=> !busy);
    p_write_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> cpu_stall);
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd_pend |=> !s_q.rd_pend);
    p_read_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_blk |=> (err_rd_busy && !s_q.rd_pend));
endmodule

// File: tb/nvm_ctrl_tb.sv
module nvm_ctrl_tb;
    localparam int PROG = 2500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cpu_stall, err_corrupt, err_rd_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nvm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_stall(cpu_stall),
        .err_corrupt(err_corrupt), .err_rd_busy(err_rd_busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // caller is at a falling edge; drive, take one rising edge, return at next falling edge
    task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [7:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic nv_read(input logic [8:0] a, output logic [7:0] val);
        reg_write(2'd0, a[7:0]);
        reg_write(2'd1, {7'd0, a[8]});
        reg_write(2'd3, 8'h01);
        repeat (4) @(negedge clk);
        peek(2'd2, val);
    endtask

    task automatic wait_idle(output int cycles_busy);
        logic [7:0] c;
        cycles_busy = 0;
        peek(2'd3, c);
        while (c[1] && cycles_busy < 10000) begin
            cycles_busy++;
            @(negedge clk);
            peek(2'd3, c);
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(2'd3, v);
        chk_eq("R1 ctrl after reset", v, 8'h00);
        chk_eq("R1 stall after reset", cpu_stall, 0);
        chk_eq("R1 errors after reset", {err_corrupt, err_rd_busy}, 0);
        nv_read(9'h000, v);
        chk_eq("R1 erased byte at 0x000", v, 8'hFF);
        nv_read(9'h1FF, v);
        chk_eq("R1 erased byte at 0x1FF", v, 8'hFF);
    endtask

    task automatic t_arm_window;
        logic [7:0] v;
        reg_write(2'd3, 8'h04);
        peek(2'd3, v);
        chk_eq("R2 arm bit set", v, 8'h04);
        repeat (3) @(negedge clk);
        peek(2'd3, v);
        chk_eq("R2 arm held through E+3", v, 8'h04);
        @(negedge clk);
        peek(2'd3, v);
        chk_eq("R2 arm cleared at E+4", v, 8'h00);
        reg_write(2'd3, 8'h06);
        peek(2'd3, v);
        chk_eq("R2 arm refused with strobe bit", v, 8'h00);
        chk_eq("R4 no stall from unarmed strobe", cpu_stall, 0);
    endtask

    task automatic t_unarmed_write;
        logic [7:0] v;
        reg_write(2'd0, 8'h05);
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, 8'h3C);
        reg_write(2'd3, 8'h02);
        peek(2'd3, v);
        chk_eq("R4 strobe without arm ignored", v, 8'h00);
        chk_eq("R4 no stall", cpu_stall, 0);
        // late strobe at E+5
        reg_write(2'd3, 8'h04);
        repeat (3) @(negedge clk);
        reg_write(2'd3, 8'h02);
        peek(2'd3, v);
        chk_eq("R4 strobe after window ignored", v, 8'h00);
        nv_read(9'h005, v);
        chk_eq("R4 array unchanged", v, 8'hFF);
    endtask

    task automatic t_write_path;
        logic [7:0] v;
        int n;
        reg_write(2'd0, 8'h21);
        reg_write(2'd1, 8'h01);
        reg_write(2'd2, 8'hA5);
        reg_write(2'd3, 8'h04);
        repeat (2) @(negedge clk);
        reg_write(2'd3, 8'h02);   // lands on E+4
        peek(2'd3, v);
        chk_eq("R3 strobe at last window edge accepted", v, 8'h02);
        chk_eq("R5 stall cycle 1", cpu_stall, 1);
        @(negedge clk);
        chk_eq("R5 stall cycle 2", cpu_stall, 1);
        @(negedge clk);
        chk_eq("R5 stall ends after 2", cpu_stall, 0);
        wait_idle(n);
        chk_eq("R3 busy length", n + 2, PROG);
        nv_read(9'h121, v);
        chk_eq("R3 R9 stored byte at 0x121", v, 8'hA5);
        nv_read(9'h021, v);
        chk_eq("R9 high part distinguishes 0x021", v, 8'hFF);
    endtask

    task automatic t_read_timing;
        logic [7:0] v;
        reg_write(2'd0, 8'h21);
        reg_write(2'd1, 8'h01);
        reg_write(2'd2, 8'h00);
        reg_write(2'd3, 8'h01);
        peek(2'd3, v);
        chk_eq("R6 read bit set after strobe", v, 8'h01);
        chk_eq("R6 stall after strobe", cpu_stall, 1);
        @(negedge clk);
        peek(2'd3, v);
        chk_eq("R6 read bit cleared", v, 8'h00);
        peek(2'd2, v);
        chk_eq("R6 data loaded", v, 8'hA5);
        repeat (2) @(negedge clk);
        chk_eq("R6 stall at E+3", cpu_stall, 1);
        @(negedge clk);
        chk_eq("R6 stall ends after 4", cpu_stall, 0);
    endtask

    task automatic t_busy_errors;
        logic [7:0] v;
        int n;
        reg_write(2'd0, 8'h40);
        reg_write(2'd2, 8'h77);
        reg_write(2'd3, 8'h04);
        reg_write(2'd3, 8'h02);
        repeat (3) @(negedge clk);
        reg_write(2'd2, 8'h11);
        chk_eq("R7 corrupt flag on data write", err_corrupt, 1);
        @(negedge clk);
        chk_eq("R7 corrupt flag is one cycle", err_corrupt, 0);
        reg_write(2'd0, 8'h41);
        chk_eq("R7 corrupt flag on address write", err_corrupt, 1);
        reg_write(2'd3, 8'h01);
        chk_eq("R8 refused read flag", err_rd_busy, 1);
        peek(2'd3, v);
        chk_eq("R8 R10 ctrl shows busy only", v, 8'h02);
        @(negedge clk);
        chk_eq("R8 flag is one cycle", err_rd_busy, 0);
        peek(2'd2, v);
        chk_eq("R8 data register kept", v, 8'h11);
        wait_idle(n);
        check(n < PROG, "R3 busy ends", n, PROG);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        reg_write(2'd1, 8'hFF);
        peek(2'd1, v);
        chk_eq("R10 high part zero-extended", v, 8'h01);
        reg_write(2'd0, 8'h9C);
        peek(2'd0, v);
        chk_eq("R10 low byte readback", v, 8'h9C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm_window();
        t_unarmed_write();
        t_write_path();
        t_read_timing();
        t_busy_errors();
        t_readback();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule